// File: doc/BRIEF.md
# Post-Fill Duplicate Detection Engine

This engine checks one freshly filled, not-yet-analysed data-array entry of a deduplicating last-level cache for an identical copy already stored elsewhere. The cache controller starts it once per miss, so the work overlaps the outstanding memory access. The engine folds the entry's data into a short hash. The low bits of that hash select a bucket of a small associative hash table, and the remaining bits form a partial hash. The engine then walks the bucket's nodes in order, lowest first.

A full data comparison is requested from the caller only for a valid node whose partial hash equals that of the analysed data. Each comparison takes one cycle. For every valid node, the caller also reports whether the pointed-to entry is referenced by a single tag.

At the end the engine reports one of four outcomes with a one-cycle done pulse: merge into a matching entry, insert a new node, evict a node pointing to an unshared entry and insert, or abandon. Relinking tags, freeing entries and adjusting reference counts are left to the caller, which can also clear nodes that name a freed entry through an invalidate port.

Top module: `dedup_engine`

## Requirements
- R1: The data is reduced by five cascaded XOR halvings (upper half XOR lower half) to a hash of DATA_W/32 bits. The bucket is hash bits [BKT_W-1:0], and the partial hash is the PH_W bits directly above them. Nodes in other buckets are never consulted.
- R2: `look_cmp` is asserted only while busy, and only for a valid node of the selected bucket whose stored partial hash equals the analysed one.
- R3: When `look_cmp` and `look_eq` are both high in a cycle, the scan stops. Done follows with code 0 (merge) and `res_idx` equal to that node's pointer. The table is not changed.
- R4: When no node matches and the bucket has an invalid node, the lowest invalid node receives the analysed index and partial hash. The result is code 1 (insert) with `res_idx` equal to the analysed index.
- R5: When no node matches, the bucket is full and at least one node had `look_sole` high, the lowest such node is overwritten with the analysed entry. The result is code 2 (evict) with `res_idx` equal to the old pointer of that node.
- R6: When no node matches, the bucket is full and no node is unshared, the result is code 3 (abandon) and the table is left unchanged.
- R7: `busy` rises the cycle after an accepted `start`. While busy, `lock_idx` holds the analysed index. A `start` while busy is ignored. `busy` falls in the same cycle that `done` is raised.
- R8: A cycle with `inv_en` high clears every valid node, in any bucket, whose pointer equals `inv_ptr`.
- R9: `done` is high for exactly one cycle per accepted start.
- R10: After reset, the table is empty, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin analysis of one entry (accepted when idle) |
| start_idx | input | PTR_W | Data-array index of the analysed entry |
| start_data | input | DATA_W | Data of the analysed entry |
| busy | output | 1 | Analysis in progress |
| lock_idx | output | PTR_W | Entry to be kept locked while busy |
| look_cmp | output | 1 | Request a full compare of the analysed data with entry `look_idx` |
| look_idx | output | PTR_W | Pointer stored in the node currently scanned |
| look_eq | input | 1 | Same-cycle compare answer: the data are equal |
| look_sole | input | 1 | Same-cycle answer: entry `look_idx` has exactly one tag |
| inv_en | input | 1 | Clear nodes naming `inv_ptr` |
| inv_ptr | input | PTR_W | Pointer to purge from the table |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 2 | 0 merge, 1 insert, 2 evict and insert, 3 abandon |
| res_idx | output | PTR_W | Matched index, evicted index, or analysed index |

## Verification
The bench builds the engine with four nodes per bucket, four buckets, a 14-bit partial hash, 8-bit pointers and 512-bit data. With these values, a bucket fills after four inserts, so the abandon path and the lowest-unshared eviction path are reached in a short run. The data patterns put content only in the low 32 bits or only in the top 16 bits. This lets the bench choose the hash directly and build distinct blocks that share a hash, which exercises compare misses on partial-hash hits. A same-partial-hash block in a second bucket shows that bucket selection isolates the nodes.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

    typedef enum logic [1:0] {
        RES_MERGE   = 2'd0,
        RES_INSERT  = 2'd1,
        RES_EVICT   = 2'd2,
        RES_ABANDON = 2'd3
    } res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } st_e;

    localparam int FOLD_STAGES = 5;

endpackage

// File: rtl/dd_hash_fold.sv
module dd_hash_fold #(
    parameter int IN_W   = 512,
    parameter int STAGES = 5,
    localparam int OUT_W = IN_W >> STAGES
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] hash
);
    for (genvar s = 0; s < STAGES; s++) begin : g_st
        localparam int W = IN_W >> (s + 1);
        logic [W-1:0] v;
        if (s == 0) begin : g_first
            assign v = din[IN_W-1 -: W] ^ din[W-1:0];
        end else begin : g_next
            assign v = g_st[s-1].v[2*W-1 -: W] ^ g_st[s-1].v[W-1:0];
        end
    end

    assign hash = g_st[STAGES-1].v;
endmodule

// File: rtl/dd_bucket_store.sv
module dd_bucket_store #(
    parameter int NBKT  = 2,
    parameter int NODES = 16,
    parameter int PTR_W = 16,
    parameter int PH_W  = 15,
    localparam int BKT_W  = (NBKT > 1) ? $clog2(NBKT) : 1,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BKT_W-1:0]  rd_bkt,
    input  logic [NODE_W-1:0] rd_node,
    output logic              rd_vld,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PH_W-1:0]   rd_ph,
    input  logic              wr_en,
    input  logic [BKT_W-1:0]  wr_bkt,
    input  logic [NODE_W-1:0] wr_node,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PH_W-1:0]   wr_ph,
    input  logic              inv_en,
    input  logic [PTR_W-1:0]  inv_ptr
);
    logic             vld [NBKT][NODES];
    logic [PTR_W-1:0] ptr [NBKT][NODES];
    logic [PH_W-1:0]  ph  [NBKT][NODES];

    assign rd_vld = vld[rd_bkt][rd_node];
    assign rd_ptr = ptr[rd_bkt][rd_node];
    assign rd_ph  = ph[rd_bkt][rd_node];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBKT; b++)
                for (int n = 0; n < NODES; n++) begin
                    vld[b][n] <= 1'b0;
                    ptr[b][n] <= '0;
                    ph[b][n]  <= '0;
                end
        end else begin
            if (wr_en) begin
                vld[wr_bkt][wr_node] <= 1'b1;
                ptr[wr_bkt][wr_node] <= wr_ptr;
                ph[wr_bkt][wr_node]  <= wr_ph;
            end
            if (inv_en) begin
                for (int b = 0; b < NBKT; b++)
                    for (int n = 0; n < NODES; n++)
                        if (vld[b][n] && ptr[b][n] == inv_ptr)
                            vld[b][n] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dedup_engine.sv
module dedup_engine
    import dedup_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int PTR_W  = 16,
    parameter int NODES  = 16,
    parameter int BKT_W  = 1,
    parameter int PH_W   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PTR_W-1:0]  start_idx,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic [PTR_W-1:0]  lock_idx,
    output logic              look_cmp,
    output logic [PTR_W-1:0]  look_idx,
    input  logic              look_eq,
    input  logic              look_sole,
    input  logic              inv_en,
    input  logic [PTR_W-1:0]  inv_ptr,
    output logic              done,
    output logic [1:0]        res_code,
    output logic [PTR_W-1:0]  res_idx
);
    localparam int HASH_W = DATA_W >> FOLD_STAGES;
    localparam int NBKT   = 1 << BKT_W;
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1;

    logic [HASH_W-1:0] fold;
    dd_hash_fold #(.IN_W(DATA_W), .STAGES(FOLD_STAGES)) u_fold (
        .din(start_data), .hash(fold)
    );

    st_e               st;
    logic [PTR_W-1:0]  cur_idx;
    logic [BKT_W-1:0]  cur_bkt;
    logic [PH_W-1:0]   cur_ph;
    logic [NODE_W-1:0] node;
    logic              have_free, have_vict;
    logic [NODE_W-1:0] free_node, vict_node;
    logic [PTR_W-1:0]  vict_ptr;
    logic              done_q;
    res_e              res_q;
    logic [PTR_W-1:0]  res_idx_q;

    logic              n_vld;
    logic [PTR_W-1:0]  n_ptr;
    logic [PH_W-1:0]   n_ph;
    logic              wr_en;
    logic [NODE_W-1:0] wr_node;

    dd_bucket_store #(.NBKT(NBKT), .NODES(NODES), .PTR_W(PTR_W), .PH_W(PH_W)) u_tab (
        .clk(clk), .rst(rst),
        .rd_bkt(cur_bkt), .rd_node(node),
        .rd_vld(n_vld), .rd_ptr(n_ptr), .rd_ph(n_ph),
        .wr_en(wr_en), .wr_bkt(cur_bkt), .wr_node(wr_node),
        .wr_ptr(cur_idx), .wr_ph(cur_ph),
        .inv_en(inv_en), .inv_ptr(inv_ptr)
    );

    // Per-node decision terms, current node folded in with history
    logic              scanning, match, last, f_any, v_any;
    logic [NODE_W-1:0] f_node, v_node;
    logic [PTR_W-1:0]  v_ptr;

    always_comb begin
        scanning = (st == ST_SCAN);
        look_cmp = scanning && n_vld && (n_ph == cur_ph);
        look_idx = n_ptr;
        match    = look_cmp && look_eq;
        last     = (node == NODE_W'(NODES - 1));
        f_any    = have_free || !n_vld;
        f_node   = have_free ? free_node : node;
        v_any    = have_vict || (n_vld && look_sole);
        v_node   = have_vict ? vict_node : node;
        v_ptr    = have_vict ? vict_ptr  : n_ptr;
        wr_en    = scanning && !match && last && (f_any || v_any);
        wr_node  = f_any ? f_node : v_node;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_idx   <= '0;
            cur_bkt   <= '0;
            cur_ph    <= '0;
            node      <= '0;
            have_free <= 1'b0;
            have_vict <= 1'b0;
            free_node <= '0;
            vict_node <= '0;
            vict_ptr  <= '0;
            done_q    <= 1'b0;
            res_q     <= RES_ABANDON;
            res_idx_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_IDLE) begin
                if (start) begin
                    st        <= ST_SCAN;
                    cur_idx   <= start_idx;
                    cur_bkt   <= fold[BKT_W-1:0];
                    cur_ph    <= fold[BKT_W +: PH_W];
                    node      <= '0;
                    have_free <= 1'b0;
                    have_vict <= 1'b0;
                end
            end else begin
                if (match || last) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                    if (match) begin
                        res_q     <= RES_MERGE;
                        res_idx_q <= n_ptr;
                    end else if (f_any) begin
                        res_q     <= RES_INSERT;
                        res_idx_q <= cur_idx;
                    end else if (v_any) begin
                        res_q     <= RES_EVICT;
                        res_idx_q <= v_ptr;
                    end else begin
                        res_q     <= RES_ABANDON;
                        res_idx_q <= cur_idx;
                    end
                end else begin
                    node      <= node + 1'b1;
                    have_free <= f_any;
                    free_node <= f_node;
                    have_vict <= v_any;
                    vict_node <= v_node;
                    vict_ptr  <= v_ptr;
                end
            end
        end
    end

    assign busy     = scanning;
    assign lock_idx = cur_idx;
    assign done     = done_q;
    assign res_code = res_q;
    assign res_idx  = res_idx_q;
endmodule

// File: rtl/dedup_engine_chk.sv
module dedup_engine_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic [PTR_W-1:0] lock_idx,
    input logic             look_cmp,
    input logic [PTR_W-1:0] look_idx,
    input logic             look_eq,
    input logic             done,
    input logic [1:0]       res_code,
    input logic [PTR_W-1:0] res_idx
);
    // R2: compare requests only during a scan
    p_cmp_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        look_cmp |-> busy);

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: busy ends exactly when done is raised
    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: an accepted start makes the engine busy next cycle
    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7: locked index is steady for the whole scan
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lock_idx));

    // R3: a merge reports the node that answered equal
    p_merge_src_r3: assert property (@(posedge clk) disable iff (rst)
        (done && res_code == 2'd0) |->
            ($past(look_cmp) && $past(look_eq) && res_idx == $past(look_idx)));
endmodule

bind dedup_engine dedup_engine_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .lock_idx(lock_idx),
    .look_cmp(look_cmp), .look_idx(look_idx), .look_eq(look_eq),
    .done(done), .res_code(res_code), .res_idx(res_idx)
);

// File: tb/sim_dedup_engine.sv
`timescale 1ns/1ps
module sim_dedup_engine;
    localparam int DATA_W = 512;
    localparam int PTR_W  = 8;
    localparam int NODES  = 4;
    localparam int BKT_W  = 2;
    localparam int PH_W   = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [PTR_W-1:0]  start_idx = '0;
    logic [DATA_W-1:0] start_data = '0;
    logic              busy, look_cmp, done;
    logic [PTR_W-1:0]  lock_idx, look_idx, res_idx;
    logic              look_eq, look_sole;
    logic              inv_en = 1'b0;
    logic [PTR_W-1:0]  inv_ptr = '0;
    logic [1:0]        res_code;

    logic [DATA_W-1:0] mem [256];
    logic              sole [256];
    logic [DATA_W-1:0] cur_data = '0;
    int                cmp_cnt = 0;
    int                n_chk = 0;
    int                n_fail = 0;

    always #2.5 clk = ~clk;

    dedup_engine #(.DATA_W(DATA_W), .PTR_W(PTR_W), .NODES(NODES),
                   .BKT_W(BKT_W), .PH_W(PH_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_idx(start_idx),
        .start_data(start_data), .busy(busy), .lock_idx(lock_idx),
        .look_cmp(look_cmp), .look_idx(look_idx), .look_eq(look_eq),
        .look_sole(look_sole), .inv_en(inv_en), .inv_ptr(inv_ptr),
        .done(done), .res_code(res_code), .res_idx(res_idx)
    );

    // Caller model: data-array compare and single-tag query
    assign look_eq   = (mem[look_idx] == cur_data);
    assign look_sole = sole[look_idx];

    always @(posedge clk) if (look_cmp) cmp_cnt <= cmp_cnt + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] hv(input int ph, input int bkt);
        return {ph[13:0], bkt[1:0]};
    endfunction

    // Content only in low 32 bits: the fold equals h by construction
    function automatic logic [DATA_W-1:0] mk(input logic [15:0] h, input logic [15:0] salt);
        logic [DATA_W-1:0] d = '0;
        d[31:16] = salt;
        d[15:0]  = h ^ salt;
        return d;
    endfunction

    task automatic run_job(input int idx, input logic [DATA_W-1:0] d,
                           input int exp_code, input int exp_idx,
                           input int exp_cmp, input string req);
        int base;
        int waited;
        @(negedge clk);
        base       = cmp_cnt;
        cur_data   = d;
        mem[idx]   = d;
        start      = 1'b1;
        start_idx  = PTR_W'(idx);
        start_data = d;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R7", "busy after start", int'(busy), 1);
        chk(lock_idx == PTR_W'(idx), "R7", "lock_idx", int'(lock_idx), idx);
        waited = 0;
        while (done !== 1'b1 && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk(done === 1'b1, req, "done seen", int'(done), 1);
        chk(busy === 1'b0, "R7", "busy low at done", int'(busy), 0);
        chk(int'(res_code) == exp_code, req, "res_code", int'(res_code), exp_code);
        chk(int'(res_idx) == exp_idx, req, "res_idx", int'(res_idx), exp_idx);
        chk(cmp_cnt - base == exp_cmp, "R2", "compare count", cmp_cnt - base, exp_cmp);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R10", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R10", "done after reset", int'(done), 0);
    endtask

    // R4 / R3: fresh bucket insert, then identical data merges
    task automatic t_insert_merge;
        run_job(1, mk(hv(17, 1), 0), 1, 1, 0, "R4");
        run_job(2, mk(hv(17, 1), 0), 0, 1, 1, "R3");
    endtask

    // R2 / R4: same hash different data compares once then inserts
    task automatic t_collide_fill;
        run_job(3, mk(hv(17, 1), 16'h0005), 1, 3, 1, "R2");
        run_job(4, mk(hv(34, 1), 0), 1, 4, 0, "R4");
        run_job(5, mk(hv(51, 1), 0), 1, 5, 0, "R4");
    endtask

    // R6: full bucket, all shared -> abandon, table unchanged
    task automatic t_abandon;
        run_job(6, mk(hv(68, 1), 0), 3, 6, 0, "R6");
        run_job(7, mk(hv(34, 1), 0), 0, 4, 1, "R6");
    endtask

    // R5: lowest unshared node evicted; new entry is then findable
    task automatic t_evict;
        sole[3] = 1'b1;
        sole[5] = 1'b1;
        run_job(8, mk(hv(68, 1), 0), 2, 3, 0, "R5");
        sole[3] = 1'b0;
        run_job(9, mk(hv(68, 1), 0), 0, 8, 1, "R5");
    endtask

    // R8: purge pointer 1, its node becomes free again
    task automatic t_invalidate;
        @(negedge clk);
        inv_en  = 1'b1;
        inv_ptr = 8'd1;
        @(negedge clk);
        inv_en = 1'b0;
        run_job(11, mk(hv(17, 1), 0), 1, 11, 0, "R8");
    endtask

    // R1: top-bit content folds to the same hash; other bucket isolated
    task automatic t_fold;
        logic [DATA_W-1:0] d = '0;
        d[DATA_W-1 -: 16] = hv(17, 1);
        run_job(12, d, 2, 5, 1, "R1");
        run_job(13, mk(hv(17, 2), 0), 1, 13, 0, "R1");
    endtask

    // R7 / R9: start while busy is ignored
    task automatic t_busy_start;
        int extra = 0;
        @(negedge clk);
        cur_data   = mk(hv(85, 3), 0);
        mem[20]    = cur_data;
        start      = 1'b1;
        start_idx  = 8'd20;
        start_data = cur_data;
        @(negedge clk);
        start_idx = 8'd21;
        @(negedge clk);
        start = 1'b0;
        while (done !== 1'b1 && extra < 50) begin
            @(negedge clk);
            extra++;
        end
        chk(int'(res_idx) == 20, "R7", "first start served", int'(res_idx), 20);
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done === 1'b1 || busy === 1'b1) extra++;
        end
        chk(extra == 0, "R7", "busy-time start ignored", extra, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = '0;
            sole[i] = 1'b0;
        end
        mem[0] = {DATA_W{1'b1}};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_insert_merge();
        t_collide_fill();
        t_abandon();
        t_evict();
        t_invalidate();
        t_fold();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule